// File: doc/BRIEF.md
# Strided Interleave DMA Address Generator

This block produces the address stream for a DMA channel that moves data in 16-byte quadwords between a local scratchpad and main memory using a stride-interleaved pattern. Software supplies a total quadword count, a run length, a gap length, and one start address for each side. A start pulse then launches the transfer. The block issues one quadword address pair per accepted beat. The scratchpad-side address walks through contiguous quadwords. The memory-side address moves contiguously inside a run of up to run-length quadwords, then jumps over a gap of gap-length quadwords before the next run begins. A run length of zero means the whole count forms a single run.

The same generator serves both directions. A direction input, sampled at start, decides whether the scratchpad address is the source and the memory address the destination, or the other way round. Data movement, memory and the channel register file are outside the block. When the last beat is accepted, the remaining count reads zero, the busy flag drops, a one-cycle completion pulse is given and a sticky interrupt is raised. The interrupt stays high until the next start. A start with a count of zero completes at once and issues no address.

Top module: `strided_dma_agen`

## Requirements
- R1: After reset, valid, busy, done and irq are low and qw_left is zero.
- R2: A start with total_qw of zero issues no beat. done and irq are high in the cycle after the start, and busy stays low.
- R3: The scratchpad-side address of beat k (k counted from 0) equals the aligned spr_base plus 16·k.
- R4: When run_qw is zero, the memory-side address moves contiguously across the whole count as one run.
- R5: When run_qw is T, which is not zero, beat k sits in run r = k div T. Its memory-side address equals the aligned mem_base plus 16·(k + r·skip_qw). The last run holds only the quadwords that remain.
- R6: While valid is high and rdy is low, src_addr, dst_addr and qw_left hold their values. A beat is accepted on a rising clock edge when valid and rdy are both high, so at most one beat is accepted per cycle.
- R7: qw_left equals total_qw minus the number of accepted beats while busy, and it reads zero after completion.
- R8: When the last beat is accepted, the next cycle shows busy low, done high for exactly one cycle and irq high. irq stays high until the next accepted start clears it.
- R9: A start pulse while busy is ignored. It does not change the address sequence, the count or the direction.
- R10: Both emitted addresses always have bits [3:0] equal to zero, whatever the low bits of the base addresses are.
- R11: With dir_to_spr = 0, src_addr is the scratchpad-side address and dst_addr the memory-side address. With dir_to_spr = 1 the two are swapped. Direction is captured at start.
- R12: Exactly total_qw beats are accepted before done is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; takes effect only when idle |
| dir_to_spr | input | 1 | 0: scratchpad to memory, 1: memory to scratchpad |
| total_qw | input | CNT_W | Total quadwords to move |
| run_qw | input | CNT_W | Quadwords per run; 0 means one run |
| skip_qw | input | CNT_W | Quadwords skipped on memory side after each run |
| spr_base | input | ADDR_W | Scratchpad-side start address |
| mem_base | input | ADDR_W | Memory-side start address |
| rdy | input | 1 | Downstream accepts the current beat |
| valid | output | 1 | An address pair is offered |
| src_addr | output | ADDR_W | Source quadword address |
| dst_addr | output | ADDR_W | Destination quadword address |
| qw_left | output | CNT_W | Quadwords still to be issued |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench sweeps every combination of count, run length and gap in a small range, in both directions, with several ready patterns. It compares each offered address pair with the closed-form position of that beat. A design that mishandled a partial last run, or applied the gap in the wrong place, would put the memory address of the first beat of a run off by whole gaps. A design that treated a zero run length as a run of one would insert gaps across the whole transfer. A zero count must finish without issuing any beat. An off-by-one in the terminal count would show as an extra or missing beat before done. A start pulse sent in mid-transfer, and misaligned base addresses, are also applied. A design that reloaded on that pulse would restart the sequence, and one that kept the low address bits would offer unaligned addresses.

// File: rtl/sidg_pkg.sv
package sidg_pkg;

  localparam int unsigned QW_SHIFT = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } agen_state_e;

endpackage

// File: rtl/sidg_counter.sv
module sidg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] run_len,
  input  logic             adv,
  output logic [CNT_W-1:0] remaining,
  output logic             run_end,
  output logic             last_beat
);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] run_left_q, run_left_d;
  logic [CNT_W-1:0] tlen_q, tlen_d;
  logic [CNT_W-1:0] tlen_eff;
  logic [CNT_W-1:0] rem_dec;
  logic             en;

  assign tlen_eff = (run_len == '0) ? total : run_len;
  assign rem_dec  = rem_q - 1'b1;
  assign en       = load | adv;

  always_comb begin
    rem_d      = rem_q;
    run_left_d = run_left_q;
    tlen_d     = tlen_q;
    if (load) begin
      tlen_d     = tlen_eff;
      rem_d      = total;
      run_left_d = (tlen_eff < total) ? tlen_eff : total;
    end else if (adv) begin
      rem_d = rem_dec;
      if (run_left_q == CNT_W'(1)) begin
        run_left_d = (tlen_q < rem_dec) ? tlen_q : rem_dec;
      end else begin
        run_left_d = run_left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      run_left_q <= '0;
      tlen_q     <= '0;
    end else if (en) begin
      rem_q      <= rem_d;
      run_left_q <= run_left_d;
      tlen_q     <= tlen_d;
    end
  end

  assign remaining = rem_q;
  assign run_end   = (run_left_q == CNT_W'(1));
  assign last_beat = (rem_q == CNT_W'(1));

endmodule

// File: rtl/sidg_addr_step.sv
module sidg_addr_step
  import sidg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter bit          STRIDED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  input  logic              run_end,
  input  logic [CNT_W-1:0]  skip,
  output logic [ADDR_W-1:0] ptr
);

  localparam logic [ADDR_W-1:0] QW_STEP  = ADDR_W'(1) << QW_SHIFT;
  localparam logic [ADDR_W-1:0] LOW_MASK = QW_STEP - 1'b1;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] incr;
  logic              en;

  generate
    if (STRIDED) begin : g_strided
      logic [CNT_W-1:0] skip_q;
      logic [ADDR_W-1:0] gap_step;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          skip_q <= '0;
        end else if (load) begin
          skip_q <= skip;
        end
      end

      assign gap_step = (ADDR_W'(skip_q) + 1'b1) << QW_SHIFT;
      assign incr     = run_end ? gap_step : QW_STEP;
    end else begin : g_linear
      logic unused_inputs;
      assign unused_inputs = ^{skip, run_end};
      assign incr          = QW_STEP;
    end
  endgenerate

  assign en = load | adv;

  always_comb begin
    if (load) begin
      ptr_d = base & ~LOW_MASK;
    end else begin
      ptr_d = ptr_q + incr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/strided_dma_agen.sv
module strided_dma_agen
  import sidg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_to_spr,
  input  logic [CNT_W-1:0]  total_qw,
  input  logic [CNT_W-1:0]  run_qw,
  input  logic [CNT_W-1:0]  skip_qw,
  input  logic [ADDR_W-1:0] spr_base,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic              rdy,
  output logic              valid,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  qw_left,
  output logic              busy,
  output logic              done,
  output logic              irq
);

  agen_state_e state_q, state_d;
  logic        done_q, done_d;
  logic        irq_q, irq_d;
  logic        dir_q;
  logic        load, adv, finish, zero_start;
  logic        run_end, last_beat;
  logic [ADDR_W-1:0] spr_ptr, mem_ptr;

  assign load       = start && (state_q == ST_IDLE);
  assign zero_start = load && (total_qw == '0);
  assign valid      = (state_q == ST_RUN);
  assign adv        = valid && rdy;
  assign finish     = adv && last_beat;

  sidg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .total     (total_qw),
    .run_len   (run_qw),
    .adv       (adv),
    .remaining (qw_left),
    .run_end   (run_end),
    .last_beat (last_beat)
  );

  sidg_addr_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDED(1'b0)) u_spr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .base    (spr_base),
    .adv     (adv),
    .run_end (run_end),
    .skip    (skip_qw),
    .ptr     (spr_ptr)
  );

  sidg_addr_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDED(1'b1)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .base    (mem_base),
    .adv     (adv),
    .run_end (run_end),
    .skip    (skip_qw),
    .ptr     (mem_ptr)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    irq_d   = irq_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          irq_d = zero_start;
          if (zero_start) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (finish) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          irq_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else if (load) begin
      dir_q <= dir_to_spr;
    end
  end

  assign src_addr = dir_q ? mem_ptr : spr_ptr;
  assign dst_addr = dir_q ? spr_ptr : mem_ptr;
  assign busy     = (state_q == ST_RUN);
  assign done     = done_q;
  assign irq      = irq_q;

endmodule

// File: rtl/strided_dma_agen_chk.sv
module strided_dma_agen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rdy,
  input logic              valid,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [CNT_W-1:0]  qw_left,
  input logic              busy,
  input logic              done,
  input logic              irq,
  input logic              dir_q
);

  logic [ADDR_W-1:0] spr_side;
  assign spr_side = dir_q ? dst_addr : src_addr;

  a_r10_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (src_addr[3:0] == 4'h0) && (dst_addr[3:0] == 4'h0));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !rdy |=> valid && $stable(src_addr) && $stable(dst_addr) && $stable(qw_left));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    valid && rdy |=> qw_left == $past(qw_left) - 1'b1);

  a_r3_spr_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    valid && rdy && (qw_left > CNT_W'(1)) |=> spr_side == $past(spr_side) + ADDR_W'(16));

  a_r8_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !valid && irq && (qw_left == '0));

  a_r8_finish: assert property (@(posedge clk) disable iff (!rst_n)
    valid && rdy && (qw_left == CNT_W'(1)) |=> done && !busy);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !rdy |=> busy && $stable(qw_left) && $stable(src_addr));

endmodule

bind strided_dma_agen strided_dma_agen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .rdy      (rdy),
  .valid    (valid),
  .src_addr (src_addr),
  .dst_addr (dst_addr),
  .qw_left  (qw_left),
  .busy     (busy),
  .done     (done),
  .irq      (irq),
  .dir_q    (dir_q)
);

// File: tb/strided_dma_agen_test.sv
module strided_dma_agen_test;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              dir_to_spr;
  logic [CNT_W-1:0]  total_qw, run_qw, skip_qw;
  logic [ADDR_W-1:0] spr_base, mem_base;
  logic              rdy;
  logic              valid, busy, done, irq;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [CNT_W-1:0]  qw_left;

  int checks = 0;
  int errors = 0;
  bit wd_hit = 1'b0;

  strided_dma_agen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_to_spr(dir_to_spr),
    .total_qw(total_qw), .run_qw(run_qw), .skip_qw(skip_qw),
    .spr_base(spr_base), .mem_base(mem_base), .rdy(rdy),
    .valid(valid), .src_addr(src_addr), .dst_addr(dst_addr),
    .qw_left(qw_left), .busy(busy), .done(done), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Runs one transfer; poke!=0 sends a start with other settings after beat 2.
  task automatic run_case(input int n, input int t, input int s, input bit d,
                          input logic [31:0] sb, input logic [31:0] mb,
                          input int rmode, input bit poke);
    int k = 0;
    int cyc = 0;
    bit fin = 1'b0;
    bit poked = 1'b0;
    int teff = (t == 0) ? n : t;
    logic [31:0] spr_a, mem_a, exp_src, exp_dst;
    @(negedge clk);
    total_qw = CNT_W'(n); run_qw = CNT_W'(t); skip_qw = CNT_W'(s);
    spr_base = sb; mem_base = mb; dir_to_spr = d; start = 1'b1; rdy = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R8: irq cleared by the start (set again at once only for zero count, R2)
    check(irq == (n == 0), "R8 irq after start", 64'(irq), 64'(n == 0));
    while (!fin && cyc < 400) begin
      if (valid) begin
        spr_a = (sb & 32'hFFFF_FFF0) + 32'(16 * k);
        mem_a = (mb & 32'hFFFF_FFF0) + 32'(16 * (k + (k / teff) * s));
        exp_src = d ? mem_a : spr_a;
        exp_dst = d ? spr_a : mem_a;
        check(k < n, "R12 beat count bound", 64'(k), 64'(n));
        check(src_addr == exp_src, "R3/R5/R11 src_addr", 64'(src_addr), 64'(exp_src));
        check(dst_addr == exp_dst, "R3/R4/R5/R11 dst_addr", 64'(dst_addr), 64'(exp_dst));
        check(qw_left == CNT_W'(n - k), "R7 qw_left", 64'(qw_left), 64'(n - k));
        check(busy, "R8 busy while valid", 64'(busy), 64'd1);
      end
      if (done) begin
        check(k == n, "R12 beats before done", 64'(k), 64'(n));
        check(!busy && !valid, "R8 idle at done", 64'({busy, valid}), 64'd0);
        check(irq, "R8 irq at done", 64'(irq), 64'd1);
        check(qw_left == '0, "R7 qw_left zero", 64'(qw_left), 64'd0);
        fin = 1'b1;
      end else begin
        if (poke && !poked && k == 2 && valid) begin
          rdy = 1'b0; start = 1'b1; poked = 1'b1;
          total_qw = 16'd3; run_qw = 16'd1; skip_qw = 16'd7;
          spr_base = 32'h5555_0000; mem_base = 32'hAAAA_0000; dir_to_spr = ~d;
        end else begin
          start = 1'b0;
          case (rmode)
            0: rdy = 1'b1;
            1: rdy = ((cyc * 7 + n + t) % 3) != 0;
            default: rdy = (cyc % 4) == 3;
          endcase
        end
        if (valid && rdy) k++;
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    check(fin, "R12 transfer completes", 64'(fin), 64'd1);
    @(negedge clk);
    check(!done, "R8 done is one cycle", 64'(done), 64'd0);
    check(irq, "R8 irq sticky", 64'(irq), 64'd1);
    check(!valid, "R2/R8 no beat after done", 64'(valid), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    wd_hit = 1'b1;
  end

  initial begin
    start = 1'b0; dir_to_spr = 1'b0; total_qw = '0; run_qw = '0; skip_qw = '0;
    spr_base = '0; mem_base = '0; rdy = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({valid, busy, done, irq} == 4'b0, "R1 reset outputs", 64'({valid, busy, done, irq}), 64'd0);
    check(qw_left == '0, "R1 reset qw_left", 64'(qw_left), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero count completes at once
    run_case(0, 3, 2, 1'b0, 32'h0000_1000, 32'h0002_0000, 0, 1'b0);

    // Sweep count, run length and gap, both directions (R3, R4, R5, R11, R12)
    for (int n = 0; n <= 9 && !wd_hit; n++) begin
      for (int t = 0; t <= 4; t++) begin
        for (int s = 0; s <= 3; s++) begin
          run_case(n, t, s, bit'((n + t + s) & 1), 32'h0000_0400 + 32'(n * 64),
                   32'h0010_0000 + 32'(t * 4096), (n + s) % 3, 1'b0);
        end
      end
    end

    // R10: misaligned bases are aligned
    run_case(5, 2, 3, 1'b0, 32'h0000_123F, 32'h8000_0007, 1, 1'b0);
    run_case(4, 0, 5, 1'b1, 32'hFFFF_FFE9, 32'h0000_00FF, 0, 1'b0);
    // R9: start during a transfer is ignored
    run_case(7, 2, 1, 1'b0, 32'h0000_2000, 32'h0004_0000, 0, 1'b1);
    run_case(6, 0, 2, 1'b1, 32'h0000_3000, 32'h0005_0000, 1, 1'b1);
    // R6: long stalls
    run_case(6, 4, 2, 1'b0, 32'h0000_0100, 32'h0000_8000, 2, 1'b0);

    if (wd_hit) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule